// File: doc/BRIEF.md
# Isochronous Cycle Timer Controller

This block keeps the 125 µs isochronous time base of a serial-bus link layer. A 32-bit time value made of a seconds count, a cycle count and a cycle offset advances on a 24.576 MHz clock-enable pulse. A rollover starts each new isochronous cycle. The offset then returns to zero and the cycle count advances. The cycle count carries into the seconds count when it wraps.

Control inputs choose where rollovers come from. In internal mode the offset reaches its limit and rolls over. In external mode an 8 kHz strobe triggers each rollover. A count-enable input freezes the whole timer. When the node is cycle master and the PHY reports it as root, every rollover produces a one-cycle cycle-start request. When the node is not cycle master, cycle-start times received from the bus are loaded into the timer to keep it aligned with the sender.

A watchdog guards master operation. If a cycle runs past 125 µs, a sticky cycle-too-long flag is raised and master mode is dropped. Master mode cannot be entered again until that flag has been cleared. Software can write the whole time value directly.

Top module: `cyc_timer_ctl`

## Requirements
- R1: In internal mode (`src_ext`=0) with `count_en`=1, each `tick_en` pulse adds one to the offset. The pulse that finds the offset at 3071 rolls the timer over instead: the offset becomes 0 and the cycle count goes up by one. A full cycle is therefore 3072 pulses.
- R2: A rollover with the cycle count at 7999 sets the cycle count to 0 and adds one to the seconds count. The seconds count wraps from 127 to 0.
- R3: In external mode (`src_ext`=1), only a `cyc_strobe` pulse causes a rollover. On `tick_en` the offset keeps counting past 3071 and stops at 4095.
- R4: While `count_en`=0, the time value holds. Both `tick_en` and `cyc_strobe` are ignored.
- R5: `cs_req` goes high for one cycle, in the clock cycle that follows the edge on which a rollover takes place. This happens only if `master_on`=1 and `phy_root`=1 at that edge.
- R6: While `master_on`=0, a `rx_cs_vld` pulse loads `rx_cs_time` into the time value on the next edge. While `master_on`=1, received times are ignored.
- R7: While `master_on`=1 and `phy_root`=1, the block watches for rollovers. If 3073 `tick_en` pulses arrive without a rollover in between, `too_long` is set and `master_on` is cleared on that same edge.
- R8: `mstr_set` has no effect while `too_long`=1. `tl_clr` clears `too_long`, after which `mstr_set` sets `master_on`. `mstr_clr` clears `master_on`.
- R9: `sw_wr` loads `sw_wdata` into the time value. A software write wins over a received load and over counting. The layout of the time value is seconds in [31:25], cycle count in [24:12] and offset in [11:0].
- R10: `cycle_match` equals {seconds[1:0], cycle count}, 15 bits wide.
- R11: After reset, the time value, `master_on`, `too_long` and `cs_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | 24.576 MHz count enable pulse |
| src_ext | input | 1 | 1 = rollover from external strobe |
| count_en | input | 1 | 1 = timer counts |
| mstr_set | input | 1 | Request to enter cycle-master mode |
| mstr_clr | input | 1 | Leave cycle-master mode |
| tl_clr | input | 1 | Clear the cycle-too-long flag |
| phy_root | input | 1 | PHY reports this node is root |
| cyc_strobe | input | 1 | External 8 kHz cycle strobe pulse |
| rx_cs_vld | input | 1 | Received cycle-start time is valid |
| rx_cs_time | input | 32 | Received cycle-start time value |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write value |
| timer_word | output | 32 | Current time value |
| cycle_match | output | 15 | Low seconds bits with cycle count |
| cs_req | output | 1 | Cycle-start request pulse |
| master_on | output | 1 | Cycle-master mode active |
| too_long | output | 1 | Sticky cycle-too-long flag |

## Verification
Several rules are checked by assertions on every clock:
- the internal rollover to offset 0;
- the hold while counting is disabled;
- the absence of cycle-count changes between external strobes;
- the rule that a cycle-start request needs master and root on the previous edge;
- the loading of received and software values;
- the rule that `too_long` excludes master mode.

Only the bench scenarios can show the rest: the full-width carries from cycle count into seconds and the seconds wrap, offset saturation in external mode, the exact pulse count at which the watchdog fires, and the sequence of clearing the flag and then re-entering master mode.

// File: rtl/cyc_tmr_pkg.sv
package cyc_tmr_pkg;
   localparam int SEC_W   = 7;
   localparam int CYC_W   = 13;
   localparam int OFF_W   = 12;
   localparam int WORD_W  = SEC_W + CYC_W + OFF_W;
   localparam int MATCH_W = 2 + CYC_W;

   typedef struct packed {
      logic [SEC_W-1:0] sec;
      logic [CYC_W-1:0] cyc;
      logic [OFF_W-1:0] off;
   } ctime_t;
endpackage

// File: rtl/cyc_tmr_count.sv
module cyc_tmr_count
   import cyc_tmr_pkg::*;
#(
   parameter int OFF_LIMIT  = 3072,
   parameter int CYC_LIMIT  = 8000,
   parameter bit EXT_SRC_EN = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   tick,
   input  logic   en,
   input  logic   src_ext,
   input  logic   strobe,
   input  logic   ld,
   input  ctime_t ld_val,
   output ctime_t now,
   output logic   roll
);
   localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_LIMIT - 1);
   localparam logic [OFF_W-1:0] OFF_SAT  = {OFF_W{1'b1}};
   localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_LIMIT - 1);

   logic   use_ext;
   logic   roll_int;
   logic   roll_ext;
   ctime_t nxt;

   generate
      if (EXT_SRC_EN) begin : g_ext
         assign use_ext  = src_ext;
         assign roll_ext = en & strobe & src_ext;
      end else begin : g_int_only
         assign use_ext  = 1'b0;
         assign roll_ext = 1'b0;
      end
   endgenerate

   assign roll_int = en & tick & ~use_ext & (now.off >= OFF_LAST);
   assign roll     = (roll_int | roll_ext) & ~ld;

   always_comb begin
      nxt = now;
      if (ld) begin
         nxt = ld_val;
      end else if (roll) begin
         nxt.off = '0;
         if (now.cyc >= CYC_LAST) begin
            nxt.cyc = '0;
            nxt.sec = now.sec + 1'b1;
         end else begin
            nxt.cyc = now.cyc + 1'b1;
         end
      end else if (en && tick && (now.off != OFF_SAT)) begin
         nxt.off = now.off + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now <= '0;
      else        now <= nxt;
   end
endmodule

// File: rtl/cyc_tmr_mstr.sv
module cyc_tmr_mstr #(
   parameter int OFF_LIMIT = 3072
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic root,
   input  logic roll,
   input  logic m_set,
   input  logic m_clr,
   input  logic tl_clr,
   output logic master,
   output logic too_long,
   output logic cs_req
);
   localparam int WD_W = $clog2(OFF_LIMIT + 1);
   localparam logic [WD_W-1:0] WD_TOP = WD_W'(OFF_LIMIT);

   logic [WD_W-1:0] wd;
   logic            watch;
   logic            tl_hit;

   assign watch  = master & root;
   assign tl_hit = watch & tick & ~roll & (wd == WD_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd <= '0;
      end else if (!watch || roll) begin
         wd <= '0;
      end else if (tick && (wd != WD_TOP)) begin
         wd <= wd + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         too_long <= 1'b0;
         master   <= 1'b0;
         cs_req   <= 1'b0;
      end else begin
         cs_req <= roll & master & root;
         if (tl_hit)      too_long <= 1'b1;
         else if (tl_clr) too_long <= 1'b0;
         if (tl_hit || m_clr)         master <= 1'b0;
         else if (m_set && !too_long) master <= 1'b1;
      end
   end
endmodule

// File: rtl/cyc_timer_ctl.sv
module cyc_timer_ctl
   import cyc_tmr_pkg::*;
#(
   parameter int OFF_LIMIT  = 3072,
   parameter int CYC_LIMIT  = 8000,
   parameter bit EXT_SRC_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_en,
   input  logic               src_ext,
   input  logic               count_en,
   input  logic               mstr_set,
   input  logic               mstr_clr,
   input  logic               tl_clr,
   input  logic               phy_root,
   input  logic               cyc_strobe,
   input  logic               rx_cs_vld,
   input  logic [WORD_W-1:0]  rx_cs_time,
   input  logic               sw_wr,
   input  logic [WORD_W-1:0]  sw_wdata,
   output logic [WORD_W-1:0]  timer_word,
   output logic [MATCH_W-1:0] cycle_match,
   output logic               cs_req,
   output logic               master_on,
   output logic               too_long
);
   generate
      if (OFF_LIMIT < 2 || OFF_LIMIT > (1 << OFF_W)) begin : g_bad_off
         $error("OFF_LIMIT out of range for offset field");
      end
      if (CYC_LIMIT < 2 || CYC_LIMIT > (1 << CYC_W)) begin : g_bad_cyc
         $error("CYC_LIMIT out of range for cycle field");
      end
   endgenerate

   ctime_t now;
   ctime_t ld_val;
   logic   ld;
   logic   roll;

   assign ld     = sw_wr | (rx_cs_vld & ~master_on);
   assign ld_val = sw_wr ? ctime_t'(sw_wdata) : ctime_t'(rx_cs_time);

   cyc_tmr_count #(
      .OFF_LIMIT (OFF_LIMIT),
      .CYC_LIMIT (CYC_LIMIT),
      .EXT_SRC_EN(EXT_SRC_EN)
   ) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_en),
      .en     (count_en),
      .src_ext(src_ext),
      .strobe (cyc_strobe),
      .ld     (ld),
      .ld_val (ld_val),
      .now    (now),
      .roll   (roll)
   );

   cyc_tmr_mstr #(
      .OFF_LIMIT(OFF_LIMIT)
   ) u_mstr (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_en),
      .root    (phy_root),
      .roll    (roll),
      .m_set   (mstr_set),
      .m_clr   (mstr_clr),
      .tl_clr  (tl_clr),
      .master  (master_on),
      .too_long(too_long),
      .cs_req  (cs_req)
   );

   assign timer_word  = now;
   assign cycle_match = {now.sec[1:0], now.cyc};
endmodule

// File: rtl/cyc_tmr_chk.sv
module cyc_tmr_chk
   import cyc_tmr_pkg::*;
#(
   parameter int OFF_LIMIT  = 3072,
   parameter bit EXT_SRC_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              src_ext,
   input logic              count_en,
   input logic              phy_root,
   input logic              cyc_strobe,
   input logic              rx_cs_vld,
   input logic [WORD_W-1:0] rx_cs_time,
   input logic              sw_wr,
   input logic [WORD_W-1:0] sw_wdata,
   input logic [WORD_W-1:0] timer_word,
   input logic              cs_req,
   input logic              master_on,
   input logic              too_long
);
   logic rx_ld;
   assign rx_ld = rx_cs_vld & ~master_on;

   AST_ROLL_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_ext && count_en && tick_en && !sw_wr && !rx_ld &&
       timer_word[OFF_W-1:0] == OFF_W'(OFF_LIMIT - 1)) |=> (timer_word[OFF_W-1:0] == '0)); // R1

   AST_EXT_WAITS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (EXT_SRC_EN && src_ext && !cyc_strobe && !sw_wr && !rx_ld)
      |=> $stable(timer_word[WORD_W-1:OFF_W])); // R3

   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_en && !sw_wr && !rx_ld) |=> $stable(timer_word)); // R4

   AST_REQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
      cs_req |-> $past(master_on && phy_root)); // R5

   AST_RESYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ld && !sw_wr) |=> (timer_word == $past(rx_cs_time))); // R6

   AST_TL_LOCKS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
      too_long |-> !master_on); // R8

   AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr |=> (timer_word == $past(sw_wdata))); // R9
endmodule

bind cyc_timer_ctl cyc_tmr_chk #(
   .OFF_LIMIT (OFF_LIMIT),
   .EXT_SRC_EN(EXT_SRC_EN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .src_ext   (src_ext),
   .count_en  (count_en),
   .phy_root  (phy_root),
   .cyc_strobe(cyc_strobe),
   .rx_cs_vld (rx_cs_vld),
   .rx_cs_time(rx_cs_time),
   .sw_wr     (sw_wr),
   .sw_wdata  (sw_wdata),
   .timer_word(timer_word),
   .cs_req    (cs_req),
   .master_on (master_on),
   .too_long  (too_long)
);

// File: tb/cyc_timer_ctl_tb.sv
`timescale 1ns/1ps
module cyc_timer_ctl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0, src_ext = 1'b0, count_en = 1'b0;
   logic        mstr_set = 1'b0, mstr_clr = 1'b0, tl_clr = 1'b0;
   logic        phy_root = 1'b0, cyc_strobe = 1'b0, rx_cs_vld = 1'b0, sw_wr = 1'b0;
   logic [31:0] rx_cs_time = '0, sw_wdata = '0;
   logic [31:0] timer_word;
   logic [14:0] cycle_match;
   logic        cs_req, master_on, too_long;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   cyc_timer_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .src_ext(src_ext),
      .count_en(count_en), .mstr_set(mstr_set), .mstr_clr(mstr_clr),
      .tl_clr(tl_clr), .phy_root(phy_root), .cyc_strobe(cyc_strobe),
      .rx_cs_vld(rx_cs_vld), .rx_cs_time(rx_cs_time), .sw_wr(sw_wr),
      .sw_wdata(sw_wdata), .timer_word(timer_word), .cycle_match(cycle_match),
      .cs_req(cs_req), .master_on(master_on), .too_long(too_long)
   );

   // wsec, wcyc, woff, ticks, esec, ecyc, eoff
   localparam int VEC [6][7] = '{
      '{  0,    0,    0,    10, 0,   0,  10},
      '{  0,    0, 3070,     2, 0,   1,   0},
      '{  5, 7999, 3071,     1, 6,   0,   0},
      '{127, 7999, 3071,     1, 0,   0,   0},
      '{  3,  100, 3071,     3, 3, 101,   2},
      '{  0,   42, 3071,  3073, 0,  44,   0}
   };

   function automatic logic [31:0] pk(input int s, input int c, input int o);
      return {7'(s), 13'(c), 12'(o)};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic sw_load(input logic [31:0] w);
      sw_wr = 1'b1; sw_wdata = w;
      @(negedge clk);
      sw_wr = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1;
      @(negedge clk);
      sig = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 word", timer_word, 32'h0);
      chk("R11 master", 32'(master_on), 32'h0);
      chk("R11 too_long", 32'(too_long), 32'h0);
      chk("R11 cs_req", 32'(cs_req), 32'h0);

      // R1 R2 R9 R10 vector walk
      count_en = 1'b1;
      for (int i = 0; i < 6; i++) begin
         sw_load(pk(VEC[i][0], VEC[i][1], VEC[i][2]));
         run_ticks(VEC[i][3]);
         chk("R1/R2 vector", timer_word, pk(VEC[i][4], VEC[i][5], VEC[i][6]));
         chk("R10 match", 32'(cycle_match), 32'({2'(VEC[i][4]), 13'(VEC[i][5])}));
      end

      // R4 hold while disabled
      count_en = 1'b0;
      sw_load(pk(1, 2, 3));
      run_ticks(20);
      src_ext = 1'b1;
      pulse(cyc_strobe);
      chk("R4 hold", timer_word, pk(1, 2, 3));

      // R3 external source
      count_en = 1'b1;
      sw_load(pk(0, 10, 3070));
      run_ticks(5);
      chk("R3 no internal roll", timer_word, pk(0, 10, 3075));
      pulse(cyc_strobe);
      chk("R3 strobe roll", timer_word, pk(0, 11, 0));
      sw_load(pk(0, 0, 4094));
      run_ticks(3);
      chk("R3 saturate", timer_word, pk(0, 0, 4095));
      src_ext = 1'b0;

      // R6 resync while not master
      rx_cs_vld = 1'b1; rx_cs_time = pk(9, 1234, 777);
      @(negedge clk);
      rx_cs_vld = 1'b0;
      chk("R6 resync", timer_word, pk(9, 1234, 777));
      // R9 software wins over received load
      rx_cs_vld = 1'b1; rx_cs_time = pk(2, 2, 2);
      sw_load(pk(4, 4, 4));
      rx_cs_vld = 1'b0;
      chk("R9 priority", timer_word, pk(4, 4, 4));

      // R5 cycle-start request as master and root
      phy_root = 1'b1;
      pulse(mstr_set);
      chk("R8 master set", 32'(master_on), 32'h1);
      sw_load(pk(0, 5, 3071));
      run_ticks(1);
      chk("R5 request", 32'(cs_req), 32'h1);
      chk("R5 roll value", timer_word, pk(0, 6, 0));
      @(negedge clk);
      chk("R5 single pulse", 32'(cs_req), 32'h0);

      // R6 ignored while master
      rx_cs_vld = 1'b1; rx_cs_time = pk(1, 1, 1);
      @(negedge clk);
      rx_cs_vld = 1'b0;
      chk("R6 ignored as master", timer_word, pk(0, 6, 0));

      // R5 no request when not root
      phy_root = 1'b0;
      sw_load(pk(0, 5, 3071));
      run_ticks(1);
      chk("R5 not root", 32'(cs_req), 32'h0);
      chk("R5 not root value", timer_word, pk(0, 6, 0));

      // R7 cycle too long in external mode
      phy_root = 1'b1;
      src_ext = 1'b1;
      sw_load(pk(0, 0, 0));
      run_ticks(3072);
      chk("R7 not yet", 32'(too_long), 32'h0);
      chk("R7 master kept", 32'(master_on), 32'h1);
      run_ticks(1);
      chk("R7 flag", 32'(too_long), 32'h1);
      chk("R7 master dropped", 32'(master_on), 32'h0);

      // R8 lockout then recovery
      pulse(mstr_set);
      chk("R8 locked", 32'(master_on), 32'h0);
      pulse(tl_clr);
      chk("R8 cleared", 32'(too_long), 32'h0);
      pulse(mstr_set);
      chk("R8 re-enter", 32'(master_on), 32'h1);
      pulse(mstr_clr);
      chk("R8 master clear", 32'(master_on), 32'h0);

      finish_run();
   end
endmodule